// File: doc/BRIEF.md
# Integer to Double Converter

This block turns a 64-bit integer register operand into an IEEE-754 binary64 value in one registered step. A 2-bit type code says whether the source is signed or unsigned, and whether it is 32 or 64 bits wide. A precision select picks one of two results: a full double, or a value rounded to binary32 and then written exactly in binary64 form. The caller supplies the rounding mode from the floating-point status register. The block returns the result together with the status information an FP unit needs: a fraction-inexact bit, a fraction-rounded bit, a 5-bit result class code, and sticky inexact and summary bits.

A conversion starts when `start` is high on a clock edge. Exactly one cycle later the result and flags appear with a single-cycle `done` pulse. When the conversion is exact by construction (a 32-bit source in double mode), the status fields keep their old values and `flag_wr` stays low. Every other conversion rounds and writes the status fields.

Top module: `i2d_top`

## Requirements
- R1: Type code `itype` selects the source: 0 = signed 32-bit, 1 = unsigned 32-bit, 2 = signed 64-bit, 3 = unsigned 64-bit. For codes 0 and 1, bits 63:32 of `operand` have no effect on any output.
- R2: A zero operand gives +0.0 (all result bits zero). A negative signed operand gives a result with bit 63 set and the magnitude of its two's-complement value.
- R3: In double mode (`single_sel` = 0) with a 32-bit type, the result is exact and `flag_wr` is 0. `frac_inexact`, `frac_rounded`, `fpclass` and both sticky bits keep their previous values.
- R4: 64-bit sources in double mode round to a 53-bit significand. The mode comes from `rmode`: 00 = nearest-even, 01 = toward zero, 10 = toward +infinity, 11 = toward -infinity.
- R5: In single mode (`single_sel` = 1), every type rounds to a 24-bit significand using `rmode`, and the result is that binary32 value in binary64 format, so result bits 28:0 are zero. `flag_wr` is 1.
- R6: When `flag_wr` is 1, `frac_inexact` is 1 exactly when the result differs from the source value, and `frac_rounded` is 1 exactly when rounding increased the magnitude.
- R7: `xx_sticky` and `fx_sticky` are set together by any inexact conversion. Only reset clears them.
- R8: When `flag_wr` is 1, `fpclass` takes the class of the result: 00010 = +zero, 00100 = +normal, 01000 = -normal.
- R9: `done` goes high for exactly one cycle, in the cycle after `start` was sampled. The result and flags are valid in that cycle.
- R10: After reset, `done`, `flag_wr`, `result`, `frac_inexact`, `frac_rounded`, `fpclass`, `xx_sticky` and `fx_sticky` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start strobe; operands are sampled with it |
| operand | input | 64 | Integer source operand |
| itype | input | 2 | Source type code |
| single_sel | input | 1 | 1 = round to binary32 precision |
| rmode | input | 2 | Rounding mode |
| result | output | 64 | binary64 result |
| done | output | 1 | Result valid pulse |
| flag_wr | output | 1 | Status fields written by this conversion |
| frac_inexact | output | 1 | Result is inexact |
| frac_rounded | output | 1 | Magnitude was incremented |
| fpclass | output | 5 | Result class code |
| xx_sticky | output | 1 | Sticky inexact exception |
| fx_sticky | output | 1 | Sticky exception summary |

## Verification
The bench targets the following corner cases:
- **Round-up carry.** All-ones 64-bit inputs must carry into the exponent when rounded up. A design that drops the carry gives a fraction of zero with an exponent one too small.
- **Ties under nearest-even.** Just above 2^53, both directions of the tie are exercised. Rounding the wrong way shows up as an off-by-one fraction and a wrong `frac_rounded`.
- **Sign and directed modes.** The most negative and almost-most-negative signed values check that a directed mode uses the sign. A design that ignores the sign rounds -(2^63-1) the wrong way.
- **Exact 32-bit double conversions.** Conversions with garbage in the upper operand bits must hold the previous flags. A design that rewrites them loses the earlier class and inexact values.
- **Single mode.** This mode must clear the low fraction bits and round at bit 29 rather than at bit 0.

// File: rtl/i2d_pkg.sv
package i2d_pkg;
  localparam int XLEN    = 64;
  localparam int EXP_W   = 11;
  localparam int FRAC_W  = 52;
  localparam int SFRAC_W = 23;
  localparam int BIAS    = 1023;
  localparam int POS_W   = $clog2(XLEN);

  typedef enum logic [1:0] {RM_NEAR = 2'b00, RM_ZERO = 2'b01,
                            RM_PINF = 2'b10, RM_NINF = 2'b11} rmode_e;

  localparam logic [4:0] CLS_PZERO = 5'b00010;
  localparam logic [4:0] CLS_NZERO = 5'b10010;
  localparam logic [4:0] CLS_PNORM = 5'b00100;
  localparam logic [4:0] CLS_NNORM = 5'b01000;

  // Integer sources only reach zero or normal values, in either precision.
  function automatic logic [4:0] class_of(input logic [XLEN-1:0] d);
    logic is_zero;
    is_zero = (d[XLEN-2:0] == '0);
    if (is_zero) return d[XLEN-1] ? CLS_NZERO : CLS_PZERO;
    return d[XLEN-1] ? CLS_NNORM : CLS_PNORM;
  endfunction
endpackage

// File: rtl/i2d_operand.sv
module i2d_operand #(
  parameter int XLEN = 64,
  parameter int HALF = XLEN / 2
) (
  input  logic [XLEN-1:0] op,
  input  logic [1:0]      itype,
  output logic            sign,
  output logic [XLEN-1:0] mag
);
  logic [HALF-1:0] lo;
  logic [HALF-1:0] lo_neg;
  logic [XLEN-1:0] full_neg;
  logic            is_signed;

  always_comb begin
    is_signed = ~itype[0];
    lo        = op[HALF-1:0];
    lo_neg    = -lo;
    full_neg  = -op;
    if (!itype[1]) begin
      sign = is_signed & lo[HALF-1];
      mag  = {{(XLEN-HALF){1'b0}}, (sign ? lo_neg : lo)};
    end else begin
      sign = is_signed & op[XLEN-1];
      mag  = sign ? full_neg : op;
    end
  end
endmodule

// File: rtl/i2d_normalize.sv
module i2d_normalize #(
  parameter int XLEN  = 64,
  parameter int POS_W = $clog2(XLEN)
) (
  input  logic [XLEN-1:0]  mag,
  output logic [XLEN-1:0]  norm,
  output logic [POS_W-1:0] msb_pos,
  output logic             is_zero
);
  always_comb begin
    msb_pos = '0;
    for (int i = 0; i < XLEN; i++) begin
      if (mag[i]) msb_pos = POS_W'(i);
    end
    is_zero = (mag == '0);
    norm    = mag << (POS_W'(XLEN - 1) - msb_pos);
  end
endmodule

// File: rtl/i2d_round.sv
module i2d_round
  import i2d_pkg::*;
#(
  parameter int XL   = 64,
  parameter int FW   = 52,
  parameter int SFW  = 23,
  parameter int DROP = XL - 1 - FW,
  parameter int SSH  = FW - SFW
) (
  input  logic [XL-1:0] norm,
  input  logic          sign,
  input  logic          single_sel,
  input  logic [1:0]    rmode,
  output logic [FW-1:0] frac,
  output logic          carry,
  output logic          inexact,
  output logic          inc
);
  localparam logic [FW:0] SMASK = {{(FW+1-SSH){1'b1}}, {SSH{1'b0}}};
  localparam logic [FW+1:0] UNIT_D = (FW+2)'(1);
  localparam logic [FW+1:0] UNIT_S = (FW+2)'(1) << SSH;

  logic [FW:0]   keep;
  logic [FW+1:0] sum;
  logic          g_bit, s_bit, l_bit;

  always_comb begin
    keep = norm[XL-1 -: FW+1];
    if (single_sel) begin
      g_bit = norm[DROP+SSH-1];
      s_bit = |norm[DROP+SSH-2:0];
      l_bit = norm[DROP+SSH];
      keep  = keep & SMASK;
    end else begin
      g_bit = norm[DROP-1];
      s_bit = |norm[DROP-2:0];
      l_bit = norm[DROP];
    end
    inexact = g_bit | s_bit;
    case (rmode_e'(rmode))
      RM_NEAR: inc = g_bit & (s_bit | l_bit);
      RM_ZERO: inc = 1'b0;
      RM_PINF: inc = inexact & ~sign;
      default: inc = inexact & sign;
    endcase
    sum   = {1'b0, keep} + (inc ? (single_sel ? UNIT_S : UNIT_D) : '0);
    carry = sum[FW+1];
    frac  = carry ? '0 : sum[FW-1:0];
  end
endmodule

// File: rtl/i2d_top.sv
module i2d_top
  import i2d_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [63:0] operand,
  input  logic [1:0]  itype,
  input  logic        single_sel,
  input  logic [1:0]  rmode,
  output logic [63:0] result,
  output logic        done,
  output logic        flag_wr,
  output logic        frac_inexact,
  output logic        frac_rounded,
  output logic [4:0]  fpclass,
  output logic        xx_sticky,
  output logic        fx_sticky
);
  logic             sign_c;
  logic [XLEN-1:0]  mag_c, norm_c;
  logic [POS_W-1:0] pos_c;
  logic             zero_c;
  logic [FRAC_W-1:0] frac_c;
  logic             carry_c, inexact_c, inc_c;
  logic [EXP_W-1:0] exp_c;
  logic [XLEN-1:0]  res_c;
  logic             upd_c;

  i2d_operand #(.XLEN(XLEN)) u_op (
    .op(operand), .itype(itype), .sign(sign_c), .mag(mag_c));

  i2d_normalize #(.XLEN(XLEN), .POS_W(POS_W)) u_norm (
    .mag(mag_c), .norm(norm_c), .msb_pos(pos_c), .is_zero(zero_c));

  i2d_round #(.XL(XLEN), .FW(FRAC_W), .SFW(SFRAC_W)) u_rnd (
    .norm(norm_c), .sign(sign_c), .single_sel(single_sel), .rmode(rmode),
    .frac(frac_c), .carry(carry_c), .inexact(inexact_c), .inc(inc_c));

  always_comb begin
    exp_c = EXP_W'(BIAS) + EXP_W'(pos_c) + EXP_W'(carry_c);
    res_c = zero_c ? '0 : {sign_c, exp_c, frac_c};
    upd_c = single_sel | itype[1];
  end

  logic [63:0] res_d;
  logic        done_d, wr_d, fi_d, fr_d, xx_d, fx_d;
  logic [4:0]  cls_d;
  logic        wr_en;

  always_comb begin
    wr_en  = start & upd_c;
    done_d = start;
    wr_d   = wr_en;
    res_d  = start ? res_c : result;
    fi_d   = wr_en ? inexact_c : frac_inexact;
    fr_d   = wr_en ? inc_c : frac_rounded;
    cls_d  = wr_en ? class_of(res_c) : fpclass;
    xx_d   = xx_sticky | (wr_en & inexact_c);
    fx_d   = fx_sticky | (wr_en & inexact_c);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result       <= '0;
      done         <= 1'b0;
      flag_wr      <= 1'b0;
      frac_inexact <= 1'b0;
      frac_rounded <= 1'b0;
      fpclass      <= '0;
      xx_sticky    <= 1'b0;
      fx_sticky    <= 1'b0;
    end else begin
      result       <= res_d;
      done         <= done_d;
      flag_wr      <= wr_d;
      frac_inexact <= fi_d;
      frac_rounded <= fr_d;
      fpclass      <= cls_d;
      xx_sticky    <= xx_d;
      fx_sticky    <= fx_d;
    end
  end
endmodule

// File: rtl/i2d_chk.sv
module i2d_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [1:0]  itype,
  input logic        single_sel,
  input logic [63:0] result,
  input logic        done,
  input logic        flag_wr,
  input logic        frac_inexact,
  input logic        frac_rounded,
  input logic [4:0]  fpclass,
  input logic        xx_sticky,
  input logic        fx_sticky
);
  AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(start)); // R9
  AST_EXACT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !$past(single_sel) && !$past(itype[1])) |-> !flag_wr); // R3
  AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_wr |-> ($stable(frac_inexact) && $stable(frac_rounded) && $stable(fpclass))); // R3
  AST_SINGLE_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(single_sel)) |-> (result[28:0] == '0 && flag_wr)); // R5
  AST_ROUNDED_IS_INEXACT: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr && frac_rounded) |-> frac_inexact); // R6
  AST_INEXACT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr && frac_inexact) |-> (xx_sticky && fx_sticky)); // R7
  AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    xx_sticky |=> xx_sticky); // R7
  AST_CLASS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    flag_wr |-> ($countones(fpclass[3:0]) == 1)); // R8
endmodule

bind i2d_top i2d_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .itype(itype),
  .single_sel(single_sel), .result(result), .done(done), .flag_wr(flag_wr),
  .frac_inexact(frac_inexact), .frac_rounded(frac_rounded),
  .fpclass(fpclass), .xx_sticky(xx_sticky), .fx_sticky(fx_sticky));

// File: tb/tb_i2d_top.sv
module tb_i2d_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] operand = '0;
  logic [1:0]  itype = '0;
  logic        single_sel = 1'b0;
  logic [1:0]  rmode = '0;
  logic [63:0] result;
  logic        done, flag_wr, frac_inexact, frac_rounded, xx_sticky, fx_sticky;
  logic [4:0]  fpclass;

  always #2 clk = ~clk;

  i2d_top dut (
    .clk(clk), .rst_n(rst_n), .start(start), .operand(operand), .itype(itype),
    .single_sel(single_sel), .rmode(rmode), .result(result), .done(done),
    .flag_wr(flag_wr), .frac_inexact(frac_inexact), .frac_rounded(frac_rounded),
    .fpclass(fpclass), .xx_sticky(xx_sticky), .fx_sticky(fx_sticky));

  typedef struct {
    logic [63:0] res;
    logic        wr, fi, fr, xx;
    logic [4:0]  cls;
    string       req;
  } item_t;

  item_t exp_q[$];
  int    n_checks = 0;
  int    n_fail = 0;
  int    n_vec = 0;
  bit    finished = 0;

  logic       h_fi = 0, h_fr = 0, h_xx = 0;
  logic [4:0] h_cls = '0;

  localparam logic [4:0] PZ = 5'b00010, PN = 5'b00100, NN = 5'b01000;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  task automatic drive(input logic [1:0] it, input logic sp, input logic [1:0] rm,
                       input logic [63:0] op, input logic [63:0] eres,
                       input logic efi, input logic efr, input logic [4:0] ecls,
                       input string req);
    item_t t;
    logic wr;
    wr = sp | it[1];
    if (wr) begin
      h_fi = efi; h_fr = efr; h_cls = ecls;
      h_xx = h_xx | efi;
    end
    t.res = eres; t.wr = wr; t.fi = h_fi; t.fr = h_fr; t.cls = h_cls;
    t.xx = h_xx; t.req = req;
    exp_q.push_back(t);
    @(negedge clk);
    operand = op; itype = it; single_sel = sp; rmode = rm; start = 1'b1;
    @(negedge clk);
    start = 1'b0; operand = {$random, $random};
    @(negedge clk);
    chk("R9", "done not a single pulse", {63'd0, done}, 64'd0);
    n_vec++;
  endtask

  // Monitor: pops one expected item per done pulse.
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        chk("R9", "unexpected done", 64'd1, 64'd0);
      end else begin
        item_t e;
        e = exp_q.pop_front();
        chk(e.req, "result", result, e.res);
        chk("R3", "flag_wr", {63'd0, flag_wr}, {63'd0, e.wr});
        chk("R6", "frac_inexact", {63'd0, frac_inexact}, {63'd0, e.fi});
        chk("R6", "frac_rounded", {63'd0, frac_rounded}, {63'd0, e.fr});
        chk("R8", "fpclass", {59'd0, fpclass}, {59'd0, e.cls});
        chk("R7", "xx_sticky", {63'd0, xx_sticky}, {63'd0, e.xx});
        chk("R7", "fx_sticky", {63'd0, fx_sticky}, {63'd0, e.xx});
      end
    end
  end

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (finished) break;
    end
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10", "reset result", result, 64'd0);
    chk("R10", "reset flags",
        {56'd0, done, flag_wr, frac_inexact, frac_rounded, xx_sticky, fx_sticky, 2'b00},
        64'd0);
    chk("R10", "reset class", {59'd0, fpclass}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 R3: 32-bit double mode, upper bits garbage, flags untouched
    drive(2'd0, 0, 2'b00, 64'hDEADBEEF_00000005, 64'h4014000000000000, 0, 0, 0, "R1");
    drive(2'd0, 0, 2'b11, 64'h12345678_FFFFFFFF, 64'hBFF0000000000000, 0, 0, 0, "R2");
    drive(2'd1, 0, 2'b01, 64'hFFFFFFFF_FFFFFFFF, 64'h41EFFFFFFFE00000, 0, 0, 0, "R1");
    // R2 R8: zero
    drive(2'd2, 0, 2'b00, 64'd0, 64'd0, 0, 0, PZ, "R2");
    // R4: all-ones unsigned 64
    drive(2'd3, 0, 2'b01, '1, 64'h43EFFFFFFFFFFFFF, 1, 0, PN, "R4");
    drive(2'd3, 0, 2'b00, '1, 64'h43F0000000000000, 1, 1, PN, "R4");
    drive(2'd3, 0, 2'b11, '1, 64'h43EFFFFFFFFFFFFF, 1, 0, PN, "R4");
    drive(2'd3, 0, 2'b10, '1, 64'h43F0000000000000, 1, 1, PN, "R4");
    // R4 R2: sign-aware directed modes
    drive(2'd2, 0, 2'b11, 64'h8000000000000001, 64'hC3E0000000000000, 1, 1, NN, "R4");
    drive(2'd2, 0, 2'b10, 64'h8000000000000001, 64'hC3DFFFFFFFFFFFFF, 1, 0, NN, "R4");
    // R3: held flags from the previous conversion
    drive(2'd0, 0, 2'b00, 64'h0000000000000005, 64'h4014000000000000, 0, 0, 0, "R3");
    // R4: nearest-even ties
    drive(2'd2, 0, 2'b00, 64'h0020000000000001, 64'h4340000000000000, 1, 0, PN, "R4");
    drive(2'd2, 0, 2'b00, 64'h0020000000000003, 64'h4340000000000002, 1, 1, PN, "R4");
    // R5: single mode
    drive(2'd0, 1, 2'b00, 64'hABCD0000_01000001, 64'h4170000000000000, 1, 0, PN, "R5");
    drive(2'd0, 1, 2'b10, 64'h00000000_01000001, 64'h4170000020000000, 1, 1, PN, "R5");
    // R7: exact conversion keeps sticky set
    drive(2'd2, 0, 2'b00, 64'h8000000000000000, 64'hC3E0000000000000, 0, 0, NN, "R7");
    drive(2'd0, 1, 2'b01, 64'h0000000000000007, 64'h401C000000000000, 0, 0, PN, "R5");
    drive(2'd3, 1, 2'b01, '1, 64'h43EFFFFFE0000000, 1, 0, PN, "R5");
    repeat (3) @(negedge clk);
    chk("R9", "pending items", 64'(exp_q.size()), 64'd0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule